// File: doc/BRIEF.md
# DDR Bank Timing and Auto-Precharge Tracker

This block sits beside the command path of a four-bank DDR memory controller. It keeps, for each bank, whether a row is open and how many cycles have passed since the events that constrain the next command. Every cycle it judges the presented command against those counters and reports on `cmd_ok`, in the same cycle, whether the command may be issued. A command that is judged illegal is discarded: state is not updated, and `cmd_err` pulses for one cycle on the following cycle.

Reads and writes may ask for auto-precharge. The tracker then closes the bank by itself at the earliest legal cycle. For a read, that cycle is the CAS latency after the last data beat. For a write, it is after the write recovery time. In both cases the precharge waits until the minimum row-active time has run. After that, the precharge countdown must expire before the bank can be activated again. All minimum times are parameters counted in clock cycles. The CAS latency and the burst length are inputs sampled with each column command.

Top module: `bank_timing_tracker`

## Requirements
- R1: After reset every bank is closed and ready (`bank_ready` all ones, `bank_open` all zeros), `cmd_err` is low, and a no-op is judged legal.
- R2: Command codes are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge one bank, 5 precharge all, 6 refresh, 7 mode set. An activate is legal only when the bank is closed, at least TRC cycles have passed since that bank's previous activate, TRP cycles have passed since its precharge began, and TRRD cycles have passed since an activate to any bank. A legal activate opens the bank.
- R3: A read needs an open bank and TRCD_RD cycles since its activate. A write needs an open bank and TRCD_WR cycles since its activate.
- R4: An explicit precharge of one bank needs an open bank, TRAS cycles since its activate, the read burst finished (burst cycles after the read), and the write recovery done (burst cycles plus TWR after the write). It closes the bank, and `bank_ready` returns TRP cycles later.
- R5: A non-no-op command that breaks any rule drives `cmd_ok` low in its cycle and `cmd_err` high for exactly the next cycle, and it changes no state.
- R6: A read with auto-precharge issued in cycle t begins precharge in cycle t + 2·CL + BL/2 − 1, where CL is 3 when `cas_sel`=0 and 4 when `cas_sel`=1. The bank is ready TRP cycles after that.
- R7: Auto-precharge never begins before TRAS cycles have passed since the bank's activate. The bank stays open until then.
- R8: A write with auto-precharge issued in cycle t begins precharge no earlier than cycle t + BL/2 + TWR.
- R9: A read or write without auto-precharge leaves the bank open.
- R10: `burst_sel` 0, 1, 2, 3 selects 2, 4, 8 or a full page of FULL_PAGE_BEATS beats. It occupies BL/2 cycles, because data moves on both clock edges.
- R11: A refresh needs every bank ready. A mode set needs every bank closed with its precharge done. After a refresh, every command is refused for TRFC cycles. After a mode set, every command is refused for TMRD cycles.
- R12: A precharge-all closes every open bank. It is illegal if any open bank does not yet meet the rules of R4.
- R13: While a bank's auto-precharge is pending, a read, write or precharge to that bank is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_bank | input | 2 | Target bank |
| cmd_ap | input | 1 | Auto-precharge request for read/write |
| cas_sel | input | 1 | CAS latency: 0 for 3, 1 for 4 |
| burst_sel | input | 2 | Burst length select (see R10) |
| cmd_ok | output | 1 | Presented command is legal this cycle |
| cmd_err | output | 1 | One-cycle pulse after a refused command |
| bank_ready | output | 4 | Bank may be activated (ignoring cross-bank spacing) |
| bank_open | output | 4 | Bank has an open row |

## Verification
An auto-precharge firing on one bank can coincide with an accepted command to another bank. The most telling case is an activate whose legality depends on shared spacing state. The bench provokes this directly: it places an activate to bank 0 in the exact cycle that bank 3's read auto-precharge comes due. It then checks that the activate is accepted, that bank 3 closes and bank 0 opens on the same edge, and that bank 3 becomes ready exactly TRP cycles later. Random traffic creates many more such overlaps, and each cycle is judged against a timestamp model built from the requirements.

// File: rtl/bt_pkg.sv
// Shared command and bank-state types for the bank timing tracker.
package bt_pkg;
    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ACT  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_PRE  = 3'd4,
        OP_PREA = 3'd5,
        OP_REF  = 3'd6,
        OP_MRS  = 3'd7
    } bt_op_e;

    typedef enum logic {
        BK_CLOSED = 1'b0,
        BK_OPEN   = 1'b1
    } bt_bank_e;
endpackage

// File: rtl/bt_bank.sv
// One bank's timing state. Counts cycles since activate (saturating at TRC),
// the remaining precharge time, the remaining hold before an explicit
// precharge, and a pending auto-precharge countdown.
// Assumes the top only asserts a do_* strobe for a legal command, and that
// at most one strobe is active per cycle.
module bt_bank
    import bt_pkg::*;
#(
    parameter int TRC     = 12,
    parameter int TRAS    = 8,
    parameter int TRCD_RD = 4,
    parameter int TRCD_WR = 2,
    parameter int TRP     = 4,
    parameter int CW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_act,
    input  logic          do_rd,
    input  logic          do_wr,
    input  logic          do_pre,
    input  logic          use_ap,
    input  logic [CW-1:0] col_hold,
    input  logic [CW-1:0] ap_delay,
    output logic          is_open,
    output logic          may_act,
    output logic          may_rd,
    output logic          may_wr,
    output logic          may_pre,
    output logic          quiet
);
    localparam logic [CW-1:0] TRC_C   = CW'(TRC);
    localparam logic [CW-1:0] TRAS_C  = CW'(TRAS);
    localparam logic [CW-1:0] TRCDR_C = CW'(TRCD_RD);
    localparam logic [CW-1:0] TRCDW_C = CW'(TRCD_WR);
    localparam logic [CW-1:0] TRP_M1  = CW'(TRP - 1);

    bt_bank_e      st;
    logic [CW-1:0] since_act, rp_left, hold_left, ap_left, hold_dec;
    logic          ap_pend, ap_fire, col;

    // Auto-precharge fires once its countdown ends and row-active time is met.
    always_comb begin
        col      = do_rd | do_wr;
        hold_dec = (hold_left == '0) ? '0 : hold_left - CW'(1);
        ap_fire  = ap_pend && (ap_left == '0) && (since_act >= TRAS_C);
    end

    // Bank state and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= BK_CLOSED;
            since_act <= TRC_C;
            rp_left   <= '0;
            hold_left <= '0;
            ap_pend   <= 1'b0;
            ap_left   <= '0;
        end else begin
            if (do_act)
                since_act <= CW'(1);
            else if (since_act < TRC_C)
                since_act <= since_act + CW'(1);

            if (do_act)
                st <= BK_OPEN;
            else if (do_pre || ap_fire)
                st <= BK_CLOSED;

            if (do_pre || ap_fire)
                rp_left <= TRP_M1;
            else if (rp_left != '0)
                rp_left <= rp_left - CW'(1);

            if (col)
                hold_left <= (col_hold > hold_dec) ? col_hold : hold_dec;
            else
                hold_left <= hold_dec;

            if (col && use_ap)
                ap_pend <= 1'b1;
            else if (ap_fire)
                ap_pend <= 1'b0;

            if (col && use_ap)
                ap_left <= ap_delay;
            else if (ap_left != '0)
                ap_left <= ap_left - CW'(1);
        end
    end

    // Per-command permission flags seen by the top.
    always_comb begin
        is_open = (st == BK_OPEN);
        quiet   = !is_open && (rp_left == '0);
        may_act = quiet && (since_act >= TRC_C);
        may_rd  = is_open && !ap_pend && (since_act >= TRCDR_C);
        may_wr  = is_open && !ap_pend && (since_act >= TRCDW_C);
        may_pre = is_open && !ap_pend && (since_act >= TRAS_C) && (hold_left == '0);
    end

    // R4: a bank only closes once the row-active minimum has run
    a_r4_close_after_tras: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BK_CLOSED && $past(st) == BK_OPEN) |-> ($past(since_act) >= TRAS_C));

    // R2: a bank only reopens once its precharge time has expired
    a_r2_reopen_after_trp: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BK_OPEN && $past(st) == BK_CLOSED) |-> ($past(rp_left) == '0));

    // R13: no column command reaches a bank with auto-precharge pending
    a_r13_no_col_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd || do_wr) |-> !ap_pend);
endmodule

// File: rtl/bt_glob.sv
// Cross-bank timing: activate-to-activate spacing and the all-bank busy
// window after a refresh or a mode set. Assumes strobes come only for
// accepted commands.
module bt_glob #(
    parameter int TRRD = 2,
    parameter int TRFC = 14,
    parameter int TMRD = 2,
    parameter int CW   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic do_act,
    input  logic do_ref,
    input  logic do_mrs,
    input  logic any_accept,
    output logic rrd_ok,
    output logic busy
);
    logic [CW-1:0] rrd_left, busy_left;

    // Down-counters for the spacing windows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrd_left  <= '0;
            busy_left <= '0;
        end else begin
            if (do_act)
                rrd_left <= CW'(TRRD - 1);
            else if (rrd_left != '0)
                rrd_left <= rrd_left - CW'(1);

            if (do_ref)
                busy_left <= CW'(TRFC - 1);
            else if (do_mrs)
                busy_left <= CW'(TMRD - 1);
            else if (busy_left != '0)
                busy_left <= busy_left - CW'(1);
        end
    end

    // Window status for the legality decode.
    always_comb begin
        rrd_ok = (rrd_left == '0);
        busy   = (busy_left != '0);
    end

    // R11: nothing is accepted inside a refresh or mode-set window
    a_r11_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !any_accept);
endmodule

// File: rtl/bank_timing_tracker.sv
// Top of the bank timing tracker. Decodes the presented command, judges it
// against the per-bank and global counters, and issues update strobes only
// for legal commands. Assumes one command per cycle and four banks at most
// addressed by cmd_bank.
module bank_timing_tracker
    import bt_pkg::*;
#(
    parameter int BANKS           = 4,
    parameter int TRC             = 12,
    parameter int TRFC            = 14,
    parameter int TRAS            = 8,
    parameter int TRCD_RD         = 4,
    parameter int TRCD_WR         = 2,
    parameter int TRP             = 4,
    parameter int TRRD            = 2,
    parameter int TMRD            = 2,
    parameter int TWR             = 2,
    parameter int CL_LO           = 3,
    parameter int CL_HI           = 4,
    parameter int FULL_PAGE_BEATS = 256,
    parameter int BW              = $clog2(BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cmd_op,
    input  logic [BW-1:0]    cmd_bank,
    input  logic             cmd_ap,
    input  logic             cas_sel,
    input  logic [1:0]       burst_sel,
    output logic             cmd_ok,
    output logic             cmd_err,
    output logic [BANKS-1:0] bank_ready,
    output logic [BANKS-1:0] bank_open
);
    localparam int BC_FULL = FULL_PAGE_BEATS / 2;
    localparam int MAXD    = 2 * CL_HI + BC_FULL + TWR;
    localparam int M1      = (MAXD > TRFC) ? MAXD : TRFC;
    localparam int M2      = (M1 > TRC) ? M1 : TRC;
    localparam int CW      = $clog2(M2 + 1);

    bt_op_e           op;
    logic [CW-1:0]    cl, bc, rd_hold, wr_hold, rd_ap, col_hold, ap_delay;
    logic [BANKS-1:0] open_v, mact_v, mrd_v, mwr_v, mpre_v, quiet_v;
    logic             legal, accept, rrd_ok, busy, err_q;

    // Latency, burst cycles and the derived hold/delay values.
    always_comb begin
        op = bt_op_e'(cmd_op);
        cl = cas_sel ? CW'(CL_HI) : CW'(CL_LO);
        case (burst_sel)
            2'd0:    bc = CW'(1);
            2'd1:    bc = CW'(2);
            2'd2:    bc = CW'(4);
            default: bc = CW'(BC_FULL);
        endcase
        rd_hold  = bc - CW'(1);
        wr_hold  = bc + CW'(TWR) - CW'(1);
        rd_ap    = (cl << 1) + bc - CW'(2);
        col_hold = (op == OP_RD) ? rd_hold : wr_hold;
        ap_delay = (op == OP_RD) ? rd_ap : wr_hold;
    end

    // Legality of the presented command.
    always_comb begin
        case (op)
            OP_NOP:  legal = 1'b1;
            OP_ACT:  legal = !busy && rrd_ok && mact_v[cmd_bank];
            OP_RD:   legal = !busy && mrd_v[cmd_bank];
            OP_WR:   legal = !busy && mwr_v[cmd_bank];
            OP_PRE:  legal = !busy && mpre_v[cmd_bank];
            OP_PREA: legal = !busy && (&(~open_v | mpre_v));
            OP_REF:  legal = !busy && (&mact_v);
            default: legal = !busy && (&quiet_v);
        endcase
        accept = legal && (op != OP_NOP);
    end

    // Per-bank trackers.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic sel;
        assign sel = accept && (cmd_bank == BW'(b));
        bt_bank #(
            .TRC(TRC), .TRAS(TRAS), .TRCD_RD(TRCD_RD), .TRCD_WR(TRCD_WR),
            .TRP(TRP), .CW(CW)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .do_act   (sel && op == OP_ACT),
            .do_rd    (sel && op == OP_RD),
            .do_wr    (sel && op == OP_WR),
            .do_pre   ((sel && op == OP_PRE) || (accept && op == OP_PREA && open_v[b])),
            .use_ap   (cmd_ap),
            .col_hold (col_hold),
            .ap_delay (ap_delay),
            .is_open  (open_v[b]),
            .may_act  (mact_v[b]),
            .may_rd   (mrd_v[b]),
            .may_wr   (mwr_v[b]),
            .may_pre  (mpre_v[b]),
            .quiet    (quiet_v[b])
        );
    end

    // Cross-bank spacing and refresh/mode-set windows.
    bt_glob #(.TRRD(TRRD), .TRFC(TRFC), .TMRD(TMRD), .CW(CW)) u_glob (
        .clk        (clk),
        .rst_n      (rst_n),
        .do_act     (accept && op == OP_ACT),
        .do_ref     (accept && op == OP_REF),
        .do_mrs     (accept && op == OP_MRS),
        .any_accept (accept),
        .rrd_ok     (rrd_ok),
        .busy       (busy)
    );

    // One-cycle error pulse for a refused command.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= (op != OP_NOP) && !legal;
    end

    assign cmd_ok     = legal;
    assign cmd_err    = err_q;
    assign bank_ready = mact_v;
    assign bank_open  = open_v;

    // R12: an accepted precharge-all leaves no bank open
    a_r12_prea_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_PREA) |=> (bank_open == '0));
endmodule

// File: tb/sim_bank_timing_tracker.sv
`timescale 1ns/1ps
module sim_bank_timing_tracker;
    localparam int TRC = 12, TRFC = 14, TRAS = 8, TRCD_RD = 4, TRCD_WR = 2;
    localparam int TRP = 4, TRRD = 2, TMRD = 2, TWR = 2, FULLB = 256;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [1:0] cmd_bank = 2'd0, burst_sel = 2'd0;
    logic       cmd_ap = 1'b0, cas_sel = 1'b0;
    logic       cmd_ok, cmd_err;
    logic [3:0] bank_ready, bank_open;

    bank_timing_tracker u0 (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cmd_ap(cmd_ap), .cas_sel(cas_sel), .burst_sel(burst_sel),
        .cmd_ok(cmd_ok), .cmd_err(cmd_err), .bank_ready(bank_ready),
        .bank_open(bank_open)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0, n = 0;
    bit prev_bad = 0;
    bit s_ok, s_err;
    logic [3:0] s_ready, s_open;
    // Timestamp model: cycle numbers of the last events per bank.
    int m_open[4], m_act[4], m_pre[4], m_hold[4], m_apon[4], m_apt[4];
    int m_lastact = -1000, m_busy = 0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, n, act, exp);
        end
    endtask

    function automatic int bcyc(int bs);
        case (bs) 0: return 1; 1: return 2; 2: return 4; default: return FULLB / 2; endcase
    endfunction
    function automatic bit e_ready(int b);
        return !m_open[b] && n >= m_pre[b] + TRP && n >= m_act[b] + TRC;
    endfunction
    function automatic bit e_quiet(int b);
        return !m_open[b] && n >= m_pre[b] + TRP;
    endfunction
    function automatic bit e_prek(int b);
        return m_open[b] && !m_apon[b] && n >= m_act[b] + TRAS && n >= m_hold[b];
    endfunction
    function automatic bit e_legal(int op, int b);
        bit nb = (n >= m_busy);
        bit all_p = 1, all_r = 1, all_q = 1;
        for (int i = 0; i < 4; i++) begin
            if (m_open[i] && !e_prek(i)) all_p = 0;
            if (!e_ready(i)) all_r = 0;
            if (!e_quiet(i)) all_q = 0;
        end
        case (op)
            0: return 1;
            1: return nb && n >= m_lastact + TRRD && e_ready(b);
            2: return nb && m_open[b] && !m_apon[b] && n >= m_act[b] + TRCD_RD;
            3: return nb && m_open[b] && !m_apon[b] && n >= m_act[b] + TRCD_WR;
            4: return nb && e_prek(b);
            5: return nb && all_p;
            6: return nb && all_r;
            default: return nb && all_q;
        endcase
    endfunction
    function automatic string tag_of(int op);
        case (op) 1: return "R2"; 2, 3: return "R3"; 4: return "R4";
            5: return "R12"; 6, 7: return "R11"; default: return "R1"; endcase
    endfunction

    // Drive one command for one cycle, compare everything, advance the model.
    task automatic step(int op, int b = 0, int ap = 0, int cs = 0, int bs = 0);
        bit lg;
        bit fire[4];
        @(negedge clk);
        cmd_op = 3'(op); cmd_bank = 2'(b); cmd_ap = ap[0]; cas_sel = cs[0]; burst_sel = 2'(bs);
        #2;
        lg = e_legal(op, b);
        s_ok = cmd_ok; s_err = cmd_err; s_ready = bank_ready; s_open = bank_open;
        chk(tag_of(op), cmd_ok, lg);
        chk("R5", cmd_err, prev_bad);
        for (int i = 0; i < 4; i++) begin
            chk("R6", bank_ready[i], e_ready(i));
            chk("R9", bank_open[i], m_open[i]);
            fire[i] = m_apon[i] && n >= m_apt[i] && n >= m_act[i] + TRAS;
        end
        prev_bad = (op != 0) && !lg;
        @(posedge clk);
        for (int i = 0; i < 4; i++)
            if (fire[i]) begin m_open[i] = 0; m_pre[i] = n; m_apon[i] = 0; end
        if (lg) begin
            case (op)
                1: begin m_open[b] = 1; m_act[b] = n; m_lastact = n; end
                2, 3: begin
                    int h = n + bcyc(bs) + ((op == 3) ? TWR : 0);
                    if (h > m_hold[b]) m_hold[b] = h;
                    if (ap != 0) begin
                        m_apon[b] = 1;
                        m_apt[b] = (op == 2) ? n + 2 * (cs ? 4 : 3) + bcyc(bs) - 1
                                             : n + bcyc(bs) + TWR;
                    end
                end
                4: begin m_open[b] = 0; m_pre[b] = n; end
                5: for (int i = 0; i < 4; i++) if (m_open[i]) begin m_open[i] = 0; m_pre[i] = n; end
                6: m_busy = n + TRFC;
                7: m_busy = n + TMRD;
                default: ;
            endcase
        end
        n++;
    endtask

    task automatic nop_to(int target);
        while (n < target) step(0);
    endtask
    task automatic look(int target);
        nop_to(target);
        step(0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int a, t, seed;
        for (int i = 0; i < 4; i++) begin
            m_open[i] = 0; m_act[i] = -1000; m_pre[i] = -1000;
            m_hold[i] = -1000; m_apon[i] = 0; m_apt[i] = 0;
        end
        seed = $urandom(32'h1a2b);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        step(0);
        chk("R1", s_ready, 4'hf); chk("R1", s_open, 0); chk("R1", s_err, 0);

        // R6 / R10: read auto-precharge, CL 3, burst of 2
        step(1, 0); a = n - 1;
        nop_to(a + TRCD_RD);
        step(2, 0, 1, 0, 0); t = n - 1;
        look(t + 2 * 3 + 1 - 1 + TRP - 1); chk("R6", s_ready[0], 0);
        step(0);                           chk("R6", s_ready[0], 1);

        // R7 / R8: write auto-precharge held off by row-active time
        step(1, 1); a = n - 1;
        nop_to(a + TRCD_WR);
        step(3, 1, 1, 0, 0);
        look(a + 6); chk("R7", s_open[1], 1);
        look(a + TRAS); chk("R7", s_open[1], 1);
        step(0); chk("R7", s_open[1], 0);

        // R8 / R10: full-page write auto-precharge
        step(1, 2); a = n - 1;
        nop_to(a + TRCD_WR);
        step(3, 2, 1, 0, 3); t = n - 1;
        look(t + FULLB / 2 + TWR); chk("R10", s_open[2], 1);
        step(0); chk("R8", s_open[2], 0);

        // R6: CL 4 read auto-precharge firing in the same cycle as an activate elsewhere
        step(1, 3); a = n - 1;
        nop_to(a + TRCD_RD);
        step(2, 3, 1, 1, 1); t = n - 1;
        nop_to(t + 2 * 4 + 2 - 1);
        step(1, 0); chk("R6", s_ok, 1);
        step(0); chk("R6", s_open[3], 0); chk("R2", s_open[0], 1);
        a = n - 2;
        look(t + 9 + TRP - 1); chk("R6", s_ready[3], 0);
        step(0); chk("R6", s_ready[3], 1);

        // R13 / R5: column command to a bank with pending auto-precharge
        nop_to(a + TRCD_RD);
        step(2, 0, 1, 0, 0); chk("R3", s_ok, 1);
        step(2, 0, 0, 0, 0); chk("R13", s_ok, 0);
        step(0); chk("R5", s_err, 1); chk("R5", s_open[0], 1);
        step(0); chk("R5", s_err, 0);
        nop_to(n + 40);

        // R2 / R12: activate spacing and precharge-all
        step(1, 1); a = n - 1;
        step(1, 2); chk("R2", s_ok, 0);
        step(1, 2); chk("R2", s_ok, 1);
        step(5); chk("R12", s_ok, 0);
        nop_to(a + 2 + TRAS);
        step(5); chk("R12", s_ok, 1);
        step(0); chk("R12", s_open[1], 0); chk("R12", s_open[2], 0);

        // R11: refresh window
        nop_to(n + TRC + TRP);
        step(6); chk("R11", s_ok, 1); t = n - 1;
        nop_to(t + TRFC - 1);
        step(1, 0); chk("R11", s_ok, 0);
        step(1, 0); chk("R11", s_ok, 1); a = n - 1;

        // R3 / R4 / R9: write recovery and early column command
        step(2, 0); chk("R3", s_ok, 0);
        nop_to(a + TRCD_RD);
        step(3, 0, 0, 0, 2); t = n - 1;
        look(t + 4 + TWR - 1 - 1);
        step(4, 0); chk("R4", s_ok, 0); chk("R9", s_open[0], 1);
        step(4, 0); chk("R4", s_ok, 1);

        // Random traffic against the model
        for (int k = 0; k < 4000; k++) begin
            int op, bs;
            op = ($urandom % 10 < 4) ? 0 : int'($urandom_range(1, 7));
            if (op >= 6 && ($urandom % 4 != 0)) op = 1;
            bs = ($urandom % 16 == 0) ? 3 : int'($urandom % 3);
            step(op, int'($urandom % 4), int'($urandom % 2), int'($urandom % 2), bs);
        end
        finish_run();
    end
endmodule